// File: doc/BRIEF.md
# RTC Interrupt Flag Generator

This block turns a fixed sampling tick, nominally 64 pulses per second, into the three interrupt sources of a classic real-time clock: a once-per-second update flag, a divided periodic flag and a time-of-day alarm flag. On each accepted tick it samples the current hours, minutes and seconds from an external timekeeper. It checks the enabled sources and, when at least one fires, it writes a status word and pulses an interrupt strobe for one cycle.

The periodic source counts ticks against a divide setting. The setting equals 64 divided by the wanted rate, so a 2 Hz rate uses 32 and a 64 Hz rate uses 1. When the tick source reports that ticks were missed, the divider counter jumps ahead by that many ticks. The reported count appears on an output. Rates above 64 Hz and the timekeeper are outside this block.

A two-state controller gates the tick path. In `S_OFF` all three enables are clear, ticks are ignored and the divider counter is held at zero. The transition `OFF_TO_RUN` fires on the first clock with any enable set and moves to `S_RUN`. The transition `RUN_TO_OFF` fires on the first clock with all enables clear and moves back to `S_OFF`. Only a tick that arrives while the controller is in `S_RUN` is processed.

Top module: `rtc_flag_gen`

## Requirements
- R1: After reset, `status_o` is 0, `irq_o` is 0, `lost_o` is 0, the recorded seconds value is 0 and the controller is in `S_OFF`.
- R2: A processed tick raises the update flag (bit 4) when `en_update_i` is 1 and `sec_i` differs from the recorded seconds value. The recorded value then takes `sec_i`. While `en_update_i` is 0 the flag stays clear and the recorded value is not changed.
- R3: On a processed tick with `en_periodic_i` at 1, the next count is the divider counter + `missed_i` + 1. If the next count is at least the limit, the periodic flag (bit 6) is raised and the counter returns to 0; otherwise the counter takes the next count. The limit is `per_div_i`, and a `per_div_i` of 0 is treated as 1.
- R4: A processed tick raises the alarm flag (bit 5) when `en_alarm_i` is 1 and hours, minutes and seconds all equal the alarm inputs. The flag is raised on every such tick, and never while `en_alarm_i` is 0.
- R5: Every processed tick rewrites `status_o`. If any flag fired, bit 7 (pending) is 1, bits 15:8 hold the count 1, bits 6:4 hold the flags and bits 3:0 are 0. If no flag fired, the word is 0.
- R6: `irq_o` is high for exactly the one cycle after a processed tick that raised a flag, and is low otherwise.
- R7: `lost_o` takes `missed_i` on each processed tick and holds between processed ticks.
- R8: In `S_OFF`, ticks are ignored: `status_o`, `lost_o` and `irq_o` do not change and the divider counter is 0. A tick in the same cycle as the first enable is still ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Sampling tick, one cycle wide |
| missed_i | input | MISS_W | Ticks lost before this tick |
| sec_i | input | SEC_W | Current seconds |
| min_i | input | MIN_W | Current minutes |
| hour_i | input | HOUR_W | Current hours |
| en_update_i | input | 1 | Update source enable |
| en_periodic_i | input | 1 | Periodic source enable |
| en_alarm_i | input | 1 | Alarm source enable |
| alm_sec_i | input | SEC_W | Alarm seconds |
| alm_min_i | input | MIN_W | Alarm minutes |
| alm_hour_i | input | HOUR_W | Alarm hours |
| per_div_i | input | DIV_W | Ticks per periodic flag (0 acts as 1) |
| status_o | output | 16 | Flag status word |
| irq_o | output | 1 | Interrupt strobe |
| lost_o | output | MISS_W | Lost-tick count of the last processed tick |

## Verification
Two pairs of sources can fire on the same tick. The update and alarm flags coincide when the seconds value changes to the alarm second. The periodic divider can reach its limit on that same tick, including when the missed-tick jump pushes it past the limit. The stimulus table builds such ticks on purpose, with the alarm at 01:02:03 and the seconds stepping onto 03 as the divider wraps. Each tick's word is compared against a value worked out by hand from the flag rules, so a source lost or merged on a shared tick shows up as a wrong bit pattern.

// File: rtl/rtc_flag_pkg.sv
package rtc_flag_pkg;
    typedef enum logic {S_OFF = 1'b0, S_RUN = 1'b1} run_state_t;

    localparam int STAT_W     = 16;
    localparam int ST_UPD     = 4;
    localparam int ST_ALM     = 5;
    localparam int ST_PER     = 6;
    localparam int ST_PEND    = 7;
    localparam int ST_CNT_LSB = 8;
    localparam int ST_CNT_W   = 8;
endpackage

// File: rtl/rtc_run_fsm.sv
module rtc_run_fsm
    import rtc_flag_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic any_en_i,
    output logic run_o
);
    run_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_OFF: if (any_en_i)  state_d = S_RUN;
            S_RUN: if (!any_en_i) state_d = S_OFF;
        endcase
    end

    always_comb run_o = (state_q == S_RUN);

    // R8: enabling always leaves S_OFF on the next edge
    a_r8_leave_off: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_OFF && any_en_i) |=> (state_q == S_RUN));
endmodule

// File: rtl/rtc_upd_det.sv
module rtc_upd_det #(
    parameter int SEC_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic [SEC_W-1:0] sec_i,
    output logic             flag_o
);
    logic [SEC_W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n)      prev_q <= '0;
        else if (step_i) prev_q <= sec_i;
    end

    assign flag_o = step_i && (sec_i != prev_q);

    // R2: recorded seconds follow the sampled value after an enabled tick
    a_r2_prev_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |=> (prev_q == $past(sec_i)));
endmodule

// File: rtl/rtc_per_div.sv
module rtc_per_div #(
    parameter int DIV_W  = 6,
    parameter int MISS_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              step_i,
    input  logic [MISS_W-1:0] miss_i,
    input  logic [DIV_W-1:0]  lim_i,
    output logic              fire_o
);
    localparam int SUM_W = ((DIV_W > MISS_W) ? DIV_W : MISS_W) + 2;

    logic [DIV_W-1:0] cnt_q;
    logic [SUM_W-1:0] nxt, lim_eff;

    assign lim_eff = (lim_i == '0) ? SUM_W'(1) : SUM_W'(lim_i);
    assign nxt     = SUM_W'(cnt_q) + SUM_W'(miss_i) + SUM_W'(1);
    assign fire_o  = step_i && (nxt >= lim_eff);

    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (clr_i)  cnt_q <= '0;
        else if (step_i) cnt_q <= fire_o ? '0 : nxt[DIV_W-1:0];
    end

    // R3: a periodic flag leaves the counter at zero
    a_r3_fire_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && fire_o) |=> (cnt_q == '0));
    // R8: counter is held at zero while the tick path is off
    a_r8_cnt_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/rtc_flag_gen.sv
module rtc_flag_gen
    import rtc_flag_pkg::*;
#(
    parameter int SEC_W  = 6,
    parameter int MIN_W  = 6,
    parameter int HOUR_W = 5,
    parameter int DIV_W  = 6,
    parameter int MISS_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [MISS_W-1:0] missed_i,
    input  logic [SEC_W-1:0]  sec_i,
    input  logic [MIN_W-1:0]  min_i,
    input  logic [HOUR_W-1:0] hour_i,
    input  logic              en_update_i,
    input  logic              en_periodic_i,
    input  logic              en_alarm_i,
    input  logic [SEC_W-1:0]  alm_sec_i,
    input  logic [MIN_W-1:0]  alm_min_i,
    input  logic [HOUR_W-1:0] alm_hour_i,
    input  logic [DIV_W-1:0]  per_div_i,
    output logic [15:0]       status_o,
    output logic              irq_o,
    output logic [MISS_W-1:0] lost_o
);
    logic run, proc, upd, per, alm, any_flag;
    logic [STAT_W-1:0] stat_d;

    rtc_run_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .any_en_i (en_update_i | en_periodic_i | en_alarm_i),
        .run_o    (run)
    );

    assign proc = run && tick_i;

    rtc_upd_det #(.SEC_W(SEC_W)) u_upd (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (proc && en_update_i),
        .sec_i  (sec_i),
        .flag_o (upd)
    );

    rtc_per_div #(.DIV_W(DIV_W), .MISS_W(MISS_W)) u_per (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (!run),
        .step_i (proc && en_periodic_i),
        .miss_i (missed_i),
        .lim_i  (per_div_i),
        .fire_o (per)
    );

    assign alm = proc && en_alarm_i && (sec_i == alm_sec_i)
                 && (min_i == alm_min_i) && (hour_i == alm_hour_i);
    assign any_flag = upd || per || alm;

    always_comb begin
        stat_d = '0;
        if (any_flag) begin
            stat_d[ST_UPD]  = upd;
            stat_d[ST_ALM]  = alm;
            stat_d[ST_PER]  = per;
            stat_d[ST_PEND] = 1'b1;
            stat_d[ST_CNT_LSB +: ST_CNT_W] = ST_CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_o <= '0;
            irq_o    <= 1'b0;
            lost_o   <= '0;
        end else begin
            irq_o <= proc && any_flag;
            if (proc) begin
                status_o <= stat_d;
                lost_o   <= missed_i;
            end
        end
    end

    // R6: strobe always comes with a pending, count-1 word
    a_r6_irq_word: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (status_o[ST_PEND] && status_o[15:8] == 8'd1));
    // R8: no strobe follows a cycle spent off
    a_r8_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !irq_o);
    // R7: lost count holds when no tick is processed
    a_r7_lost_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !proc |=> $stable(lost_o));
    // R4: an alarm bit needs the alarm enable on the tick
    a_r4_alarm_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && status_o[ST_ALM]) |-> $past(en_alarm_i));
endmodule

// File: tb/tb_rtc_flag_gen.sv
`timescale 1ns/1ps
module tb_rtc_flag_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [7:0]  missed = '0;
    logic [5:0]  sec = '0, min = '0, asec = '0, amin = '0;
    logic [4:0]  hour = '0, ahour = '0;
    logic        en_u = 1'b0, en_p = 1'b0, en_a = 1'b0;
    logic [5:0]  div = '0;
    logic [15:0] status;
    logic        irq;
    logic [7:0]  lost;
    int n_chk = 0, n_fail = 0;

    always #10 clk = ~clk;

    rtc_flag_gen dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .missed_i(missed),
        .sec_i(sec), .min_i(min), .hour_i(hour),
        .en_update_i(en_u), .en_periodic_i(en_p), .en_alarm_i(en_a),
        .alm_sec_i(asec), .alm_min_i(amin), .alm_hour_i(ahour),
        .per_div_i(div), .status_o(status), .irq_o(irq), .lost_o(lost)
    );

    // {sec, min, hour, missed, expected status}; alarm 01:02:03, divide 4
    localparam logic [40:0] VEC [10] = '{
        {6'd0, 6'd2, 5'd1, 8'd0, 16'h0000},
        {6'd0, 6'd2, 5'd1, 8'd0, 16'h0000},
        {6'd1, 6'd2, 5'd1, 8'd0, 16'h0190},
        {6'd1, 6'd2, 5'd1, 8'd0, 16'h01C0},
        {6'd1, 6'd2, 5'd1, 8'd2, 16'h0000},
        {6'd3, 6'd2, 5'd1, 8'd0, 16'h01F0},
        {6'd3, 6'd2, 5'd1, 8'd0, 16'h01A0},
        {6'd4, 6'd2, 5'd1, 8'd5, 16'h01D0},
        {6'd3, 6'd3, 5'd1, 8'd0, 16'h0190},
        {6'd3, 6'd2, 5'd2, 8'd0, 16'h0000}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [5:0] s, input logic [5:0] m, input logic [4:0] h,
                         input logic [7:0] ms, input logic [15:0] exp_st,
                         input logic exp_irq, input logic [7:0] exp_lost, input string tag);
        @(negedge clk);
        sec = s; min = m; hour = h; missed = ms; tick = 1'b1;
        @(negedge clk);
        tick = 1'b0; missed = '0;
        chk({tag, " R5 status"}, 32'(status), 32'(exp_st));
        chk({tag, " R6 irq"}, 32'(irq), 32'(exp_irq));
        chk({tag, " R7 lost"}, 32'(lost), 32'(exp_lost));
        @(negedge clk);
        chk({tag, " R6 irq drop"}, 32'(irq), 32'(0));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 status", 32'(status), 0);
        chk("R1 irq", 32'(irq), 0);
        chk("R1 lost", 32'(lost), 0);
        rst_n = 1'b1;
        asec = 6'd3; amin = 6'd2; ahour = 5'd1; div = 6'd4;
        en_u = 1'b1; en_p = 1'b1; en_a = 1'b1;
        @(negedge clk);

        // R2 R3 R4: table walk, sources coinciding on shared ticks
        for (int i = 0; i < 10; i++) begin
            apply(VEC[i][40:35], VEC[i][34:29], VEC[i][28:24], VEC[i][23:16],
                  VEC[i][15:0], VEC[i][15:0] != 16'h0, VEC[i][23:16], $sformatf("vec%0d", i));
        end

        // R2: update disabled, seconds change ignored (counter 2->3)
        en_u = 1'b0;
        apply(6'd10, 6'd2, 5'd1, 8'd0, 16'h0000, 1'b0, 8'd0, "R2 upd off");
        en_u = 1'b1;
        apply(6'd10, 6'd2, 5'd1, 8'd0, 16'h01D0, 1'b1, 8'd0, "R2 upd back");

        // R4: alarm time matches but alarm disabled (counter 0->1)
        en_a = 1'b0; en_u = 1'b0;
        apply(6'd3, 6'd2, 5'd1, 8'd0, 16'h0000, 1'b0, 8'd0, "R4 alarm off");
        en_a = 1'b1;
        apply(6'd3, 6'd2, 5'd1, 8'd0, 16'h01A0, 1'b1, 8'd0, "R4 alarm on");

        // R8: everything off, tick ignored, word held
        en_a = 1'b0; en_p = 1'b0;
        repeat (2) @(negedge clk);
        apply(6'd30, 6'd2, 5'd1, 8'd7, 16'h01A0, 1'b0, 8'd0, "R8 off tick");

        // R8: tick in the enabling cycle ignored, then counter restarts from 0
        @(negedge clk);
        en_p = 1'b1; tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        chk("R8 enable-cycle status", 32'(status), 32'h01A0);
        chk("R8 enable-cycle irq", 32'(irq), 0);
        apply(6'd30, 6'd2, 5'd1, 8'd0, 16'h0000, 1'b0, 8'd0, "R8 restart t1");
        apply(6'd30, 6'd2, 5'd1, 8'd0, 16'h0000, 1'b0, 8'd0, "R8 restart t2");
        apply(6'd30, 6'd2, 5'd1, 8'd0, 16'h0000, 1'b0, 8'd0, "R8 restart t3");
        apply(6'd30, 6'd2, 5'd1, 8'd0, 16'h01C0, 1'b1, 8'd0, "R8 restart t4");

        // R3: divide 0 acts as 1, every tick fires
        div = 6'd0;
        apply(6'd30, 6'd2, 5'd1, 8'd0, 16'h01C0, 1'b1, 8'd0, "R3 div0 a");
        apply(6'd30, 6'd2, 5'd1, 8'd0, 16'h01C0, 1'b1, 8'd0, "R3 div0 b");

        // R7 R3: large missed count passes the limit at once
        div = 6'd32;
        apply(6'd30, 6'd2, 5'd1, 8'd200, 16'h01C0, 1'b1, 8'd200, "R7 big miss");
        apply(6'd30, 6'd2, 5'd1, 8'd0, 16'h0000, 1'b0, 8'd0, "R3 after wrap");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule